// File: doc/BRIEF.md
# Stack Push/Pop Sequencer

This block keeps a byte-wide stack in an external memory for a small controller. It holds the low and high stack-pointer bytes and the program counter. It turns one command into the right series of byte transfers: a single push, a single pop, a subroutine call, a return, interrupt entry or interrupt return. Every transfer is a byte read or write request. The request stays up until the memory side answers with ready.

The stack pointer can work in one of two modes, chosen per command. In the wide mode both pointer bytes form one 16-bit pointer. In the narrow mode only the low byte moves. It wraps inside a 256-byte page at address zero, and the high byte stays free for general storage. A push moves the pointer down first and then writes. A pop reads first and then moves the pointer up. The pointer therefore always addresses the most recently stored byte. The two pointer bytes are loaded through a byte register-write port at two fixed register addresses.

Top module: `stack_engine`

## Requirements
- R1: After reset the program counter is 16'h000C. The stack pointer, flags output and pop-data output are zero. busy_o and mem_req_o are low.
- R2: A push writes its byte at address SP-1, and after the write completes SP equals that address.
- R3: A pop reads the byte at address SP, presents it on pop_data_o, and then increments SP by one.
- R4: When cmd_ext_i is 1 at command accept, SP is a 16-bit pointer {high,low} and wraps from 16'h0000 to 16'hFFFF on a push.
- R5: When cmd_ext_i is 0 at command accept, the memory address is {8'h00, low byte}. The low byte wraps modulo 256 in both directions, and the high byte is unchanged.
- R6: A call (code 2) writes the current PC low byte and then the high byte. The PC then takes cmd_target_i. The PC changes only when a command completes.
- R7: Interrupt entry (code 4) writes the PC low byte, then the high byte, then cmd_flags_i. The PC then takes cmd_target_i.
- R8: A return (code 3) reads the PC high byte and then the low byte. The PC becomes {high,low}.
- R9: Interrupt return (code 5) reads the flags byte, which appears on flags_o, then the PC high byte, then the low byte.
- R10: A register write to address 8'hFF loads the SP low byte, and one to 8'hFE loads the high byte. A write to any other address has no effect. Register writes are ignored while busy.
- R11: Command codes are push 0, pop 1, call 2, return 3, interrupt entry 4 and interrupt return 5. busy_o rises the cycle after accept and falls after the last transfer. mem_req_o is high only while busy. Commands arriving while busy are ignored.
- R12: A transfer completes on a cycle with mem_req_o and mem_ready_i both high. While ready is low, the address, direction and write data are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_ext_i | input | 1 | 1 selects the 16-bit pointer mode |
| cmd_target_i | input | 16 | New PC for call or interrupt entry |
| cmd_data_i | input | 8 | Byte to push |
| cmd_flags_i | input | 8 | Flags to save on interrupt entry |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| busy_o | output | 1 | Command in progress |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer {high,low} |
| flags_o | output | 8 | Flags restored by interrupt return |
| pop_data_o | output | 8 | Byte from the last pop |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts or returns the byte |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
The bench goes after the pointer wrap points. It pushes at 16'h0000 in the wide mode and moves across 8'h00/8'hFF in the narrow mode. A design that carried into the high byte would disturb stored data or step off the page. It checks the byte order of call, interrupt and their returns against a behavioural stack model, so a swapped low/high order or misplaced flags show up as wrong addresses or a wrong restored PC. Memory stalls are inserted so that a design that advanced a beat without ready would be caught. Commands and register writes are injected mid-sequence to catch a design that restarts or corrupts the pointer while busy.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int IDX_W  = 2;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_INTR = 3'd4,
    OP_IRET = 3'd5
  } stk_op_e;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_FLAGS = 2'd1,
    SEL_PC_HI = 2'd2,
    SEL_PC_LO = 2'd3
  } sel_e;

  typedef struct packed {
    logic we;
    sel_e sel;
  } beat_t;

  function automatic logic [IDX_W-1:0] beat_cnt(stk_op_e op);
    case (op)
      OP_CALL, OP_RET:  return IDX_W'(2);
      OP_INTR, OP_IRET: return IDX_W'(3);
      default:          return IDX_W'(1);
    endcase
  endfunction

  // beat order per command; pushes go low before high, pops mirror that
  function automatic beat_t beat_of(stk_op_e op, logic [IDX_W-1:0] idx);
    beat_t b;
    b.we  = 1'b0;
    b.sel = SEL_DATA;
    case (op)
      OP_PUSH: b.we = 1'b1;
      OP_CALL, OP_INTR: begin
        b.we = 1'b1;
        case (idx)
          IDX_W'(0): b.sel = SEL_PC_LO;
          IDX_W'(1): b.sel = SEL_PC_HI;
          default:   b.sel = SEL_FLAGS;
        endcase
      end
      OP_RET:  b.sel = (idx == IDX_W'(0)) ? SEL_PC_HI : SEL_PC_LO;
      OP_IRET: begin
        case (idx)
          IDX_W'(0): b.sel = SEL_FLAGS;
          IDX_W'(1): b.sel = SEL_PC_HI;
          default:   b.sel = SEL_PC_LO;
        endcase
      end
      default: ;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_op_i,
  input  logic       cmd_ext_i,
  input  logic       mem_ready_i,
  output logic       busy_o,
  output logic       accept_o,
  output logic       step_o,
  output logic       last_o,
  output beat_t      beat_o,
  output stk_op_e    op_o,
  output logic       mode_o
);
  logic             busy_q, mode_q;
  stk_op_e          op_q;
  logic [IDX_W-1:0] idx_q;
  logic             op_ok;

  assign op_ok    = cmd_op_i <= 3'(OP_IRET);
  assign accept_o = cmd_valid_i && !busy_q && op_ok;
  assign step_o   = busy_q && mem_ready_i;
  assign last_o   = step_o && (idx_q == beat_cnt(op_q) - IDX_W'(1));
  assign beat_o   = beat_of(op_q, idx_q);
  assign busy_o   = busy_q;
  assign op_o     = op_q;
  assign mode_o   = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      op_q   <= OP_PUSH;
      idx_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      mode_q <= cmd_ext_i;
      op_q   <= stk_op_e'(cmd_op_i);
      idx_q  <= '0;
    end else if (step_o) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SPL_ADDR = 8'hFF,
  parameter logic [BYTE_W-1:0] SPH_ADDR = 8'hFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              step_i,
  input  logic              dn_i,
  input  logic              ext_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [ADDR_W-1:0] sp_w, sp_dec, sp_inc, sp_nxt;
  logic [BYTE_W-1:0] lo_dec, lo_inc;

  always_comb begin
    sp_w   = {hi_q, lo_q};
    sp_dec = sp_w - ADDR_W'(1);
    sp_inc = sp_w + ADDR_W'(1);
    lo_dec = lo_q - BYTE_W'(1);
    lo_inc = lo_q + BYTE_W'(1);
    if (ext_i) begin
      sp_nxt = dn_i ? sp_dec : sp_inc;
      addr_o = dn_i ? sp_dec : sp_w;
    end else begin
      // narrow mode: high byte is general storage, page zero only
      sp_nxt = {hi_q, dn_i ? lo_dec : lo_inc};
      addr_o = {BYTE_W'(0), dn_i ? lo_dec : lo_q};
    end
  end

  assign sp_o = sp_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (step_i) begin
      {hi_q, lo_q} <= sp_nxt;
    end else if (wr_en_i) begin
      if (wr_addr_i == SPL_ADDR)      lo_q <= wr_data_i;
      else if (wr_addr_i == SPH_ADDR) hi_q <= wr_data_i;
    end
  end
endmodule

// File: rtl/stk_ctx.sv
module stk_ctx
  import stk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h000C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [BYTE_W-1:0] flags_i,
  input  logic              step_i,
  input  logic              last_i,
  input  beat_t             beat_i,
  input  stk_op_e           op_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [BYTE_W-1:0] flags_o,
  output logic [BYTE_W-1:0] pop_o,
  output logic [BYTE_W-1:0] wdata_o
);
  logic [ADDR_W-1:0] pc_q, tgt_q;
  logic [BYTE_W-1:0] dat_q, flg_q, hi_q, flags_q, pop_q;
  logic              rd_step;

  assign rd_step = step_i && !beat_i.we;

  always_comb begin
    case (beat_i.sel)
      SEL_FLAGS: wdata_o = flg_q;
      SEL_PC_HI: wdata_o = pc_q[ADDR_W-1:BYTE_W];
      SEL_PC_LO: wdata_o = pc_q[BYTE_W-1:0];
      default:   wdata_o = dat_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      dat_q <= '0;
      flg_q <= '0;
    end else if (accept_i) begin
      tgt_q <= target_i;
      dat_q <= data_i;
      flg_q <= flags_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      flags_q <= '0;
      pop_q   <= '0;
    end else if (rd_step) begin
      case (beat_i.sel)
        SEL_DATA:  pop_q   <= rdata_i;
        SEL_FLAGS: flags_q <= rdata_i;
        SEL_PC_HI: hi_q    <= rdata_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_PC;
    end else if (last_i) begin
      case (op_i)
        OP_CALL, OP_INTR: pc_q <= tgt_q;
        OP_RET, OP_IRET:  pc_q <= {hi_q, rdata_i};
        default:          ;
      endcase
    end
  end

  assign pc_o    = pc_q;
  assign flags_o = flags_q;
  assign pop_o   = pop_q;
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h000C,
  parameter logic [BYTE_W-1:0] SPL_ADDR = 8'hFF,
  parameter logic [BYTE_W-1:0] SPH_ADDR = 8'hFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic              cmd_ext_i,
  input  logic [ADDR_W-1:0] cmd_target_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  input  logic [BYTE_W-1:0] cmd_flags_i,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [BYTE_W-1:0] flags_o,
  output logic [BYTE_W-1:0] pop_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  logic    busy, accept, step, last, mode_q;
  beat_t   beat;
  stk_op_e op_q;

  stk_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_ext_i   (cmd_ext_i),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy),
    .accept_o    (accept),
    .step_o      (step),
    .last_o      (last),
    .beat_o      (beat),
    .op_o        (op_q),
    .mode_o      (mode_q)
  );

  stk_ptr #(.SPL_ADDR(SPL_ADDR), .SPH_ADDR(SPH_ADDR)) i_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_we_i && !busy),
    .wr_addr_i (reg_addr_i),
    .wr_data_i (reg_wdata_i),
    .step_i    (step),
    .dn_i      (beat.we),
    .ext_i     (mode_q),
    .sp_o      (sp_o),
    .addr_o    (mem_addr_o)
  );

  stk_ctx #(.RESET_PC(RESET_PC)) i_ctx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .target_i (cmd_target_i),
    .data_i   (cmd_data_i),
    .flags_i  (cmd_flags_i),
    .step_i   (step),
    .last_i   (last),
    .beat_i   (beat),
    .op_i     (op_q),
    .rdata_i  (mem_rdata_i),
    .pc_o     (pc_o),
    .flags_o  (flags_o),
    .pop_o    (pop_data_o),
    .wdata_o  (mem_wdata_o)
  );

  assign busy_o    = busy;
  assign mem_req_o = busy;
  assign mem_we_o  = beat.we;
endmodule

// File: rtl/stack_engine_chk.sv
module stack_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        mode_i,
  input logic [15:0] pc_o,
  input logic [15:0] sp_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [15:0] mem_addr_o,
  input logic        mem_ready_i
);
  AST_PUSH_PREDEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i) |=> sp_o[7:0] == $past(mem_addr_o[7:0])); // R2
  AST_POP_POSTINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ready_i) |=> sp_o[7:0] == $past(mem_addr_o[7:0]) + 8'd1); // R3
  AST_NARROW_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mode_i) |-> mem_addr_o[15:8] == 8'h00); // R5
  AST_NARROW_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mode_i) |=> $stable(sp_o[15:8])); // R5
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R11
  AST_PC_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($stable(pc_o) || ($past(busy_o) && !busy_o))); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R12
endmodule

bind stack_engine stack_engine_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mode_i      (mode_q),
  .pc_o        (pc_o),
  .sp_o        (sp_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/test_stack_engine.sv
module test_stack_engine;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0, cmd_ext_i = 1'b0;
  logic [2:0]  cmd_op_i = '0;
  logic [15:0] cmd_target_i = '0;
  logic [7:0]  cmd_data_i = '0, cmd_flags_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0, reg_wdata_i = '0;
  logic        busy_o, mem_req_o, mem_we_o, mem_ready_i = 1'b0;
  logic [15:0] pc_o, sp_o, mem_addr_o;
  logic [7:0]  flags_o, pop_data_o, mem_wdata_o, mem_rdata_i = '0;

  stack_engine i_stack_engine (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0, stall_cnt = 0;
  int m_sp = 0, m_pc = 'h000C, m_flags = 0, m_pop = 0;
  logic [7:0] mem_m [int];
  int q_we[$], q_addr[$], q_data[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_mem(input int a);
    return mem_m.exists(a) ? mem_m[a] : 8'h00;
  endfunction

  task automatic m_push(input int b, input bit ext);
    int a;
    if (ext) begin m_sp = (m_sp - 1) & 'hFFFF; a = m_sp; end
    else begin m_sp = (m_sp & 'hFF00) | ((m_sp - 1) & 'hFF); a = m_sp & 'hFF; end
    q_we.push_back(1); q_addr.push_back(a); q_data.push_back(b & 'hFF);
    mem_m[a] = 8'(b);
  endtask

  task automatic m_pop_byte(input bit ext, output int b);
    int a;
    a = ext ? m_sp : (m_sp & 'hFF);
    b = int'(rd_mem(a));
    q_we.push_back(0); q_addr.push_back(a); q_data.push_back(b);
    if (ext) m_sp = (m_sp + 1) & 'hFFFF;
    else m_sp = (m_sp & 'hFF00) | ((m_sp + 1) & 'hFF);
  endtask

  task automatic check_state(input string req);
    chk(pc_o == 16'(m_pc), {req, " pc"}, pc_o, m_pc);
    chk(sp_o == 16'(m_sp), {req, " sp"}, sp_o, m_sp);
    chk(flags_o == 8'(m_flags), {req, " flags"}, flags_o, m_flags);
    chk(pop_data_o == 8'(m_pop), {req, " pop"}, pop_data_o, m_pop);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a == 8'hFF) m_sp = (m_sp & 'hFF00) | int'(d);
    else if (a == 8'hFE) m_sp = (m_sp & 'hFF) | (int'(d) << 8);
    check_state("R10");
  endtask

  task automatic run(input int op, input int tgt, input int dat, input int flg,
                     input bit ext, input bit inject, input string req);
    int hi, lo, b, guard;
    case (op)
      0: m_push(dat, ext);
      1: begin m_pop_byte(ext, b); m_pop = b; end
      2: begin m_push(m_pc & 'hFF, ext); m_push(m_pc >> 8, ext); m_pc = tgt; end
      3: begin m_pop_byte(ext, hi); m_pop_byte(ext, lo); m_pc = (hi << 8) | lo; end
      4: begin m_push(m_pc & 'hFF, ext); m_push(m_pc >> 8, ext); m_push(flg, ext); m_pc = tgt; end
      default: begin m_pop_byte(ext, b); m_flags = b; m_pop_byte(ext, hi);
                     m_pop_byte(ext, lo); m_pc = (hi << 8) | lo; end
    endcase
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 3'(op); cmd_ext_i = ext;
    cmd_target_i = 16'(tgt); cmd_data_i = 8'(dat); cmd_flags_i = 8'(flg);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R11 busy after accept", busy_o, 1);
    guard = 0;
    while (busy_o && guard < 40) begin
      guard++;
      if (inject && guard == 1) begin
        // R11/R10: command and register write while busy must be ignored
        cmd_valid_i = 1'b1; cmd_op_i = 3'd0; cmd_data_i = 8'hEE;
        reg_we_i = 1'b1; reg_addr_i = 8'hFF; reg_wdata_i = 8'h55;
      end else begin
        cmd_valid_i = 1'b0; reg_we_i = 1'b0;
      end
      chk(mem_req_o == (q_we.size() > 0), "R11 req while work left", mem_req_o, q_we.size() > 0);
      if (mem_req_o && (stall_cnt++ % 3 != 1) && q_we.size() > 0) begin
        chk(mem_we_o == q_we[0][0], {req, " dir"}, mem_we_o, q_we[0]);
        chk(mem_addr_o == 16'(q_addr[0]), {req, " addr"}, mem_addr_o, q_addr[0]);
        if (q_we[0] == 1) chk(mem_wdata_o == 8'(q_data[0]), {req, " wdata"}, mem_wdata_o, q_data[0]);
        mem_rdata_i = rd_mem(int'(mem_addr_o));
        mem_ready_i = 1'b1;
        void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
      end else begin
        mem_ready_i = 1'b0;
      end
      @(negedge clk_i);
      mem_ready_i = 1'b0;
    end
    cmd_valid_i = 1'b0; reg_we_i = 1'b0;
    chk(guard < 40, "R12 watchdog per command", guard, 0);
    chk(q_we.size() == 0, {req, " transfer count"}, q_we.size(), 0);
    q_we.delete(); q_addr.delete(); q_data.delete();
    check_state(req);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_state("R1");
    chk(busy_o == 1'b0 && mem_req_o == 1'b0, "R1 idle", {busy_o, mem_req_o}, 0);

    reg_wr(8'hFE, 8'h12);                                  // R10 high byte
    reg_wr(8'hFF, 8'h00);                                  // R10 low byte
    reg_wr(8'h10, 8'h99);                                  // R10 other address ignored
    run(0, 0, 'hA5, 0, 1'b1, 1'b0, "R2 push wide");
    run(1, 0, 0, 0, 1'b1, 1'b0, "R3 pop wide");
    run(2, 'h0345, 0, 0, 1'b1, 1'b0, "R6 call");
    run(3, 0, 0, 0, 1'b1, 1'b0, "R8 ret");
    run(4, 'h0800, 0, 'h5A, 1'b1, 1'b0, "R7 intr");
    run(2, 'h0920, 0, 0, 1'b1, 1'b1, "R11 call with ignored cmds");
    run(3, 0, 0, 0, 1'b1, 1'b0, "R8 nested ret");
    run(5, 0, 0, 0, 1'b1, 1'b0, "R9 iret");

    reg_wr(8'hFE, 8'h77);
    reg_wr(8'hFF, 8'h01);
    run(0, 0, 'h3C, 0, 1'b0, 1'b0, "R5 push narrow to 00");
    run(0, 0, 'hC3, 0, 1'b0, 1'b0, "R5 push narrow wrap FF");
    run(4, 'h0100, 0, 'h81, 1'b0, 1'b0, "R7 intr narrow");
    run(5, 0, 0, 0, 1'b0, 1'b0, "R9 iret narrow");
    run(1, 0, 0, 0, 1'b0, 1'b0, "R5 pop narrow wrap 00");
    run(1, 0, 0, 0, 1'b0, 1'b0, "R3 pop narrow");

    reg_wr(8'hFE, 8'h00);
    reg_wr(8'hFF, 8'h00);
    run(0, 0, 'h42, 0, 1'b1, 1'b0, "R4 push wide wrap");
    run(1, 0, 0, 0, 1'b1, 1'b0, "R4 pop wide wrap");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule